// File: doc/BRIEF.md
# Manchester-coded NFC frame transmitter

The block turns a payload held in a local byte buffer into a complete coded frame for a passive NFC link. Software, or a neighbouring engine, writes the payload into the buffer: the byte at index 0 is the length byte and the command and data bytes follow it. A start request then launches the transmission.

The block frames the payload. It puts a run of zero bytes and a two-byte sync word in front of it, computes a CRC-16 over the payload and appends it, and closes the frame with two trailing zero bytes. Every bit leaves as a pair of Manchester chips, with one chip per bit-clock enable. The launch can be deferred. A release time is captured with the start request, and the frame begins only once an external free-running tick count has reached that time. This lets a responder meet a fixed reply delay measured from the end of the last received frame.

The `busy` output shows that a frame is pending or in flight. `done` pulses once when the final chip has been shown for its full period.

Top module: `nfc_frame_tx`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `done` and `chip_out` are all 0.
- R2: Each frame starts with six 0x00 bytes.
- R3: The preamble is followed by the sync byte 0xB2, then 0x4D, then buffer bytes 0 to L-1 in index order. L is the value of buffer byte 0, and L = 0 is handled as L = 1 (only the length byte is sent).
- R4: Two CRC bytes follow the payload, high byte first. The CRC uses polynomial 0x1021 with initial value 0x0000, processes bits MSB first, and covers exactly the L payload bytes. For the payload 06 00 FF FF 00 00 the CRC is 0x0921.
- R5: Bytes are sent MSB first. Each data bit 1 becomes the chip pair 1,0 and each 0 becomes 0,1. `chip_out` changes only on a clock edge where `bit_en` is 1, and takes exactly one new chip on each such edge while sending.
- R6: Two 0x00 bytes follow the CRC, so a frame has exactly 16*(L+12) chips.
- R7: `wait_time` is sampled with an accepted start. The frame is released at the first clock edge where the sampled value is 0 or `now_tick` (unsigned) is at least that value. The first chip appears at the next edge with `bit_en` high. No chip appears before release.
- R8: `busy` rises on the edge that accepts a start and stays high until the `done` edge. A start request while `busy` is high is ignored, and its `wait_time` is not captured.
- R9: On the first `bit_en` edge after the final chip has been shown, `done` is 1 for exactly one cycle, `busy` falls and `chip_out` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Payload buffer write enable |
| buf_addr | input | AW (8) | Payload buffer write index |
| buf_wdata | input | 8 | Payload buffer write data |
| start | input | 1 | Frame start request |
| wait_time | input | TICK_W (32) | Release tick, 0 means start at once |
| now_tick | input | TICK_W (32) | Free-running tick count |
| bit_en | input | 1 | Chip-rate enable |
| chip_out | output | 1 | Manchester chip stream |
| busy | output | 1 | Frame pending or in flight |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case is a start request that arrives while a frame is already in flight and carries a far-future release time. If that request were captured, its effect would only show after the current frame ends. The bench therefore fires such a request partway through a frame that runs on an irregular enable pattern. It then checks that exactly one end pulse occurs and that the block stays idle afterwards. Deferred release is driven by setting a release tick a few hundred cycles ahead and watching for chips on both sides of that boundary. The degenerate length values 0 and 1, and the full 255-byte payload, are sent as separate frames.

// File: rtl/nfc_tx_pkg.sv
package nfc_tx_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND, ST_DRAIN} tx_state_t;

  typedef enum logic [2:0] {
    PH_PRE, PH_SYNC0, PH_SYNC1, PH_PAY, PH_CRCH, PH_CRCL, PH_POST
  } tx_phase_t;

  localparam logic [7:0]  SYNC_FIRST  = 8'hB2;
  localparam logic [7:0]  SYNC_SECOND = 8'h4D;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  // One byte of CRC-16, MSB first, unrolled over eight bit steps.
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  // Chip k (0..15) of a byte: bit 7-k/2, inverted on the second half.
  function automatic logic chip_of(input logic [7:0] b, input logic [3:0] k);
    return b[3'd7 - k[3:1]] ^ k[0];
  endfunction

endpackage

// File: rtl/nfc_tx_buf.sv
module nfc_tx_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nfc_tx_crc.sv
module nfc_tx_crc
  import nfc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clear) crc <= '0;
    else if (upd)     crc <= crc_byte(crc, din);
  end

  // R4: the running CRC moves only on a payload byte or a clear
  a_r4_crc_hold: assert property (@(posedge clk) disable iff (rst)
    (!clear && !upd) |=> $stable(crc));
endmodule

// File: rtl/nfc_tx_gate.sv
module nfc_tx_gate #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [TICK_W-1:0] wait_in,
  input  logic [TICK_W-1:0] now_tick,
  output logic              release_go
);
  logic              armed;
  logic [TICK_W-1:0] wait_q;

  assign release_go = armed && ((wait_q == '0) || (now_tick >= wait_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      wait_q <= '0;
    end else if (arm) begin
      armed  <= 1'b1;
      wait_q <= wait_in;
    end else if (release_go) begin
      armed  <= 1'b0;
    end
  end

  // R7: one release per accepted start
  a_r7_one_release: assert property (@(posedge clk) disable iff (rst)
    release_go |=> !release_go);
endmodule

// File: rtl/nfc_frame_tx.sv
module nfc_frame_tx
  import nfc_tx_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int TICK_W     = 32,
  parameter int PRE_BYTES  = 6,
  parameter int POST_BYTES = 2,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_we,
  input  logic [AW-1:0]     buf_addr,
  input  logic [7:0]        buf_wdata,
  input  logic              start,
  input  logic [TICK_W-1:0] wait_time,
  input  logic [TICK_W-1:0] now_tick,
  input  logic              bit_en,
  output logic              chip_out,
  output logic              busy,
  output logic              done
);
  localparam logic [7:0] PRE_LAST  = 8'(PRE_BYTES - 1);
  localparam logic [7:0] POST_LAST = 8'(POST_BYTES - 1);

  tx_state_t     state;
  tx_phase_t     phase;
  logic [7:0]    cur_byte, cnt, len_q, mem_q;
  logic [3:0]    chip_k;
  logic [AW-1:0] rd_idx;
  logic [15:0]   crc;
  logic          release_go, accept, step, byte_end, pay_load;

  assign accept   = (state == ST_IDLE) && start;
  assign step     = (state == ST_SEND) && bit_en;
  assign byte_end = step && (chip_k == 4'd15);
  assign pay_load = byte_end &&
                    ((phase == PH_SYNC1) || ((phase == PH_PAY) && (cnt != len_q)));

  nfc_tx_buf #(.DEPTH(DEPTH), .AW(AW)) buf_i (
    .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(rd_idx), .rdata(mem_q)
  );

  nfc_tx_crc crc_i (
    .clk(clk), .rst(rst), .clear(release_go), .upd(pay_load),
    .din(mem_q), .crc(crc)
  );

  nfc_tx_gate #(.TICK_W(TICK_W)) gate_i (
    .clk(clk), .rst(rst), .arm(accept), .wait_in(wait_time),
    .now_tick(now_tick), .release_go(release_go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_PRE;
      cur_byte <= '0;
      cnt      <= '0;
      len_q    <= '0;
      chip_k   <= '0;
      rd_idx   <= '0;
      chip_out <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_WAIT;
          busy  <= 1'b1;
        end
        ST_WAIT: if (release_go) begin
          state    <= ST_SEND;
          phase    <= PH_PRE;
          cur_byte <= 8'h00;
          cnt      <= '0;
          chip_k   <= '0;
          rd_idx   <= '0;
        end
        ST_SEND: if (bit_en) begin
          chip_out <= chip_of(cur_byte, chip_k);
          chip_k   <= chip_k + 4'd1;
          if (chip_k == 4'd15) begin
            unique case (phase)
              PH_PRE: begin
                if (cnt == PRE_LAST) begin
                  phase    <= PH_SYNC0;
                  cur_byte <= SYNC_FIRST;
                end else begin
                  cnt      <= cnt + 8'd1;
                  cur_byte <= 8'h00;
                end
              end
              PH_SYNC0: begin
                phase    <= PH_SYNC1;
                cur_byte <= SYNC_SECOND;
              end
              PH_SYNC1: begin
                phase    <= PH_PAY;
                cur_byte <= mem_q;
                len_q    <= (mem_q == 8'h00) ? 8'd1 : mem_q;
                cnt      <= 8'd1;
                rd_idx   <= rd_idx + 1'b1;
              end
              PH_PAY: begin
                if (cnt == len_q) begin
                  phase    <= PH_CRCH;
                  cur_byte <= crc[15:8];
                end else begin
                  cur_byte <= mem_q;
                  cnt      <= cnt + 8'd1;
                  rd_idx   <= rd_idx + 1'b1;
                end
              end
              PH_CRCH: begin
                phase    <= PH_CRCL;
                cur_byte <= crc[7:0];
              end
              PH_CRCL: begin
                phase    <= PH_POST;
                cur_byte <= 8'h00;
                cnt      <= '0;
              end
              default: begin
                if (cnt == POST_LAST) begin
                  state <= ST_DRAIN;
                end else begin
                  cnt      <= cnt + 8'd1;
                  cur_byte <= 8'h00;
                end
              end
            endcase
          end
        end
        default: if (bit_en) begin
          state    <= ST_IDLE;
          busy     <= 1'b0;
          done     <= 1'b1;
          chip_out <= 1'b0;
        end
      endcase
    end
  end

  // R8: busy only rises after a start request
  a_r8_rise_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R9: done is a single-cycle pulse and coincides with the end of busy
  a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5: chips hold between enables
  a_r5_hold_chip: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(chip_out));

  // R3: payload count stays inside the captured length
  a_r3_pay_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && phase == PH_PAY) |-> (cnt != 8'd0 && cnt <= len_q));

  // R7: the line is quiet while waiting for release
  a_r7_quiet_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !chip_out);
endmodule

// File: tb/nfc_frame_tx_tb_top.sv
module nfc_frame_tx_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int TW    = 32;

  logic          clk = 1'b0, rst = 1'b1;
  logic          buf_we = 1'b0, start = 1'b0, bit_en = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0]    buf_wdata = '0;
  logic [TW-1:0] wait_time = '0, now_tick = '0;
  logic          chip_out, busy, done;

  int total = 0, bad = 0, cycles = 0, done_cnt = 0, d0 = 0, en_mode = 0, div = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;
  always @(posedge clk) now_tick <= now_tick + 1;

  nfc_frame_tx #(.DEPTH(DEPTH), .TICK_W(TW)) dut_i (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .start(start), .wait_time(wait_time),
    .now_tick(now_tick), .bit_en(bit_en), .chip_out(chip_out),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ser_crc(input logic [15:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // behavioural reference model
  logic [7:0]    mmem [0:DEPTH-1];
  int            m_state = 0;
  bit            m_busy = 0, m_done = 0, m_chip = 0, m_emit = 0;
  bit            m_q[$];
  logic [TW-1:0] m_wait = '0;

  task automatic m_push(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_q.push_back(b[i]);
      m_q.push_back(!b[i]);
    end
  endtask

  always @(posedge clk) begin
    if (buf_we) mmem[buf_addr] = buf_wdata;
    m_emit = 0;
    m_done = 0;
    if (rst) begin
      m_state = 0; m_busy = 0; m_chip = 0; m_q.delete();
    end else begin
      case (m_state)
        0: if (start) begin m_state = 1; m_busy = 1; m_wait = wait_time; end
        1: if (m_wait == 0 || now_tick >= m_wait) begin
          int n;
          logic [15:0] c;
          c = 16'h0000;
          n = (mmem[0] == 8'h00) ? 1 : int'(mmem[0]);
          for (int i = 0; i < 6; i++) m_push(8'h00);
          m_push(8'hB2);
          m_push(8'h4D);
          for (int i = 0; i < n; i++) begin
            m_push(mmem[i]);
            c = ser_crc(c, mmem[i]);
          end
          m_push(c[15:8]);
          m_push(c[7:0]);
          m_push(8'h00);
          m_push(8'h00);
          m_state = 2;
        end
        2: if (bit_en) begin
          m_chip = m_q.pop_front();
          m_emit = 1;
          if (m_q.size() == 0) m_state = 3;
        end
        default: if (bit_en) begin
          m_state = 0; m_busy = 0; m_done = 1; m_chip = 0;
        end
      endcase
    end
  end

  logic got[$];
  logic [7:0] dec[$];
  logic [7:0] exp_pay[$];

  always @(negedge clk) begin
    if (!rst) begin
      chk(chip_out === m_chip, "R5 chip_out per cycle", int'(chip_out), int'(m_chip));
      chk(busy === m_busy, "R8 busy per cycle", int'(busy), int'(m_busy));
      chk(done === m_done, "R9 done per cycle", int'(done), int'(m_done));
      if (m_emit) got.push_back(chip_out);
      if (done) done_cnt++;
    end
  end

  always @(negedge clk) begin
    div <= div + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (en_mode)
      0: bit_en <= 1'b1;
      1: bit_en <= (div % 3 == 0);
      default: bit_en <= lfsr[0];
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic load_buf();
    for (int i = 0; i < exp_pay.size(); i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_addr = AW'(i); buf_wdata = exp_pay[i];
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic prep(input int mode);
    en_mode = mode;
    load_buf();
    got.delete();
    d0 = done_cnt;
  endtask

  task automatic fire(input logic [TW-1:0] w);
    @(negedge clk);
    start = 1'b1; wait_time = w;
    @(negedge clk);
    start = 1'b0; wait_time = '0;
  endtask

  task automatic finish_frame();
    logic [7:0] eb[$];
    logic [15:0] c;
    int n, inval;
    for (int i = 0; i < 40000 && done_cnt == d0; i++) @(negedge clk);
    @(negedge clk);
    chk(done_cnt - d0 == 1, "R9 one done pulse per frame", done_cnt - d0, 1);
    n = (exp_pay[0] == 8'h00) ? 1 : int'(exp_pay[0]);
    c = 16'h0000;
    for (int i = 0; i < 6; i++) eb.push_back(8'h00);
    eb.push_back(8'hB2);
    eb.push_back(8'h4D);
    for (int i = 0; i < n; i++) begin
      eb.push_back(exp_pay[i]);
      c = ser_crc(c, exp_pay[i]);
    end
    eb.push_back(c[15:8]);
    eb.push_back(c[7:0]);
    eb.push_back(8'h00);
    eb.push_back(8'h00);
    chk(got.size() == 16 * eb.size(), "R6 chip count 16*(L+12)", got.size(), 16 * eb.size());
    if (got.size() == 16 * eb.size()) begin
      dec.delete();
      inval = 0;
      for (int k = 0; k < eb.size(); k++) begin
        logic [7:0] b;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
          if (got[16*k + 2*i] === got[16*k + 2*i + 1]) inval++;
          b = {b[6:0], got[16*k + 2*i]};
        end
        dec.push_back(b);
      end
      chk(inval == 0, "R5 every pair is 10 or 01", inval, 0);
      for (int k = 0; k < 6; k++) chk(dec[k] == 8'h00, "R2 preamble byte", dec[k], 0);
      chk(dec[6] == 8'hB2, "R3 first sync", dec[6], 8'hB2);
      chk(dec[7] == 8'h4D, "R3 second sync", dec[7], 8'h4D);
      for (int k = 0; k < n; k++) chk(dec[8+k] == exp_pay[k], "R3 payload byte", dec[8+k], exp_pay[k]);
      chk(dec[8+n] == c[15:8], "R4 crc high byte", dec[8+n], c[15:8]);
      chk(dec[9+n] == c[7:0], "R4 crc low byte", dec[9+n], c[7:0]);
      chk(dec[10+n] == 8'h00 && dec[11+n] == 8'h00, "R6 postamble zeros",
          {dec[10+n], dec[11+n]}, 0);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && chip_out === 1'b0, "R1 outputs in reset",
        {busy, done, chip_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && chip_out === 1'b0, "R1 outputs after reset",
        {busy, done, chip_out}, 0);

    // known poll frame, enable every cycle
    exp_pay = '{8'h06, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00};
    prep(0);
    fire('0);
    finish_frame();
    if (dec.size() >= 16) begin
      chk(dec[14] == 8'h09, "R4 known crc high", dec[14], 8'h09);
      chk(dec[15] == 8'h21, "R4 known crc low", dec[15], 8'h21);
    end

    // 20-byte random payload, enable every third cycle
    exp_pay.delete();
    exp_pay.push_back(8'd20);
    for (int i = 1; i < 20; i++) exp_pay.push_back(8'($urandom));
    prep(1);
    fire('0);
    finish_frame();

    // full-length payload
    exp_pay.delete();
    exp_pay.push_back(8'd255);
    for (int i = 1; i < 255; i++) exp_pay.push_back(8'(i * 7 + 3));
    prep(0);
    fire('0);
    finish_frame();

    // R3 length one and length zero
    exp_pay = '{8'h01};
    prep(2);
    fire('0);
    finish_frame();
    exp_pay = '{8'h00};
    prep(2);
    fire('0);
    finish_frame();

    // R7 deferred release
    exp_pay = '{8'h03, 8'h5A, 8'hC3};
    prep(0);
    begin
      logic [TW-1:0] w;
      w = now_tick + 300;
      fire(w);
      while (now_tick < w - 1) @(negedge clk);
      chk(got.size() == 0, "R7 no chip before release", got.size(), 0);
      chk(busy === 1'b1, "R8 busy while waiting", int'(busy), 1);
      repeat (4) @(negedge clk);
      chk(got.size() > 0, "R7 chips after release", got.size(), 1);
    end
    finish_frame();

    // R7 release time already passed
    prep(0);
    fire(TW'(5));
    repeat (3) @(negedge clk);
    chk(got.size() > 0, "R7 past release starts at once", got.size(), 1);
    finish_frame();

    // R8 start while busy is ignored
    exp_pay = '{8'h0A, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
    prep(2);
    fire('0);
    repeat (60) @(negedge clk);
    fire(now_tick + 5000);
    finish_frame();
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R8 ignored start left nothing pending", int'(busy), 0);
    got.delete();
    d0 = done_cnt;
    en_mode = 0;
    fire('0);
    repeat (3) @(negedge clk);
    chk(got.size() > 0, "R8 fresh start runs immediately", got.size(), 1);
    finish_frame();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule